// File: doc/BRIEF.md
# Interpolating Low-Toggle LFSR Test Pattern Source

This block is a pattern source for built-in self-test. A 36-bit linear feedback shift register steps through a maximal-length sequence. Between any two consecutive register states it emits three blended vectors, which softens each transition. Every output bit is a two-way choice between the present and the next value of its own flip-flop.

The 36 bits form four 9-bit groups. The groups switch over to the next state one after another across the blended vectors. Each bit therefore changes at most once on the way from one true state to the next, and the total number of changes over the five vectors equals the Hamming distance of the direct step. Switching activity per cycle at the input of the block under test drops, while the set of true states stays the same.

An enable input paces the output. A load request restarts from the fixed seed. A flag marks the cycles in which the output is a true register state. A strobe echoes the enable with one cycle of delay.

Top module: `lp_lfsr_gen`

## Requirements
- R1: While `rst_ni` is low and after it is released, `vec_o` equals the seed 010010100101101011010010100101101011 (leftmost character is bit 35), `anchor_o` is 1 and `valid_o` is 0.
- R2: A register step maps state s to {s[34:0], s[35]^s[10]}: a shift toward bit 35, with bit 0 taking the XOR of bit 35 and bit 10 (trinomial x^36+x^11+1).
- R3: Each clock with `en_i` high advances a phase counter 0,1,2,3,0. The register steps only on the 3-to-0 wrap. With `en_i` and `load_i` low, `vec_o` and `anchor_o` hold.
- R4: In phase p, `vec_o` bits [9g+8:9g] come from the next state for every group g < p and from the present state otherwise. In phase 0 `vec_o` is the present state.
- R5: From one true state to the next, across the five vectors, no output bit changes more than once. The number of bits changed equals the Hamming distance of the two true states.
- R6: `anchor_o` is 1 exactly in phase 0.
- R7: `valid_o` equals the value of `en_i` at the previous clock edge.
- R8: `load_i` high at a clock edge reloads the seed and sets phase 0, whatever the value of `en_i`.
- R9: With `en_i` held high from reset, the first 10,000 true states are all distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance one output vector |
| load_i | input | 1 | Reload seed and restart phase |
| vec_o | output | 36 | Test vector |
| valid_o | output | 1 | Enable delayed by one cycle |
| anchor_o | output | 1 | Output is a true register state |

## Verification
The assertions assume that `en_i` and `load_i` are known at every sampled edge. They also assume that `en_i` is low while reset is held, so the first delayed-enable comparison after release has a defined reference. The bench drives both inputs only at falling edges and holds `en_i` low during reset. Random stimulus covers mixed enable patterns and rare mid-phase loads. A long directed run with `en_i` held high covers the single-toggle and no-repeat properties.

// File: rtl/lp_lfsr_pkg.sv
package lp_lfsr_pkg;
  localparam int unsigned LFSR_W    = 36;
  localparam int unsigned N_GRP     = 4;
  localparam int unsigned TAP_STAGE = 11;
  localparam logic [LFSR_W-1:0] SEED = 36'b010010100101101011010010100101101011;
endpackage

// File: rtl/lp_lfsr_core.sv
module lp_lfsr_core #(
  parameter int unsigned W    = 36,
  parameter int unsigned TAP  = 11,
  parameter logic [W-1:0] SEED = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         load_i,
  output logic [W-1:0] state_o,
  output logic [W-1:0] next_o
);
  logic [W-1:0] state_q;

  // shift toward msb, feedback from last stage and tap stage
  assign next_o  = {state_q[W-2:0], state_q[W-1] ^ state_q[TAP-1]};
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (load_i) state_q <= SEED;
    else if (adv_i)  state_q <= next_o;
  end
endmodule

// File: rtl/lp_lfsr_phase.sv
module lp_lfsr_phase #(
  parameter int unsigned N_GRP = 4,
  localparam int unsigned PW   = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  output logic [PW-1:0] phase_o,
  output logic          wrap_o
);
  localparam logic [PW-1:0] LAST = PW'(N_GRP - 1);

  logic [PW-1:0] phase_q;

  assign phase_o = phase_q;
  assign wrap_o  = en_i && !load_i && (phase_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (load_i) phase_q <= '0;
    else if (en_i)   phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/lp_lfsr_blend.sv
module lp_lfsr_blend #(
  parameter int unsigned W     = 36,
  parameter int unsigned N_GRP = 4,
  localparam int unsigned PW   = (N_GRP > 1) ? $clog2(N_GRP) : 1,
  localparam int unsigned GW   = W / N_GRP
) (
  input  logic [W-1:0]  present_i,
  input  logic [W-1:0]  next_i,
  input  logic [PW-1:0] phase_i,
  output logic [W-1:0]  vec_o
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam logic [PW-1:0] GIDX = PW'(g);
    logic take_next;
    assign take_next = (phase_i > GIDX);
    assign vec_o[g*GW +: GW] = take_next ? next_i[g*GW +: GW] : present_i[g*GW +: GW];
  end

  if (W % N_GRP != 0) begin : g_tail
    assign vec_o[W-1:N_GRP*GW] = present_i[W-1:N_GRP*GW];
  end
endmodule

// File: rtl/lp_lfsr_gen.sv
module lp_lfsr_gen #(
  parameter int unsigned W     = lp_lfsr_pkg::LFSR_W,
  parameter int unsigned N_GRP = lp_lfsr_pkg::N_GRP,
  parameter int unsigned TAP   = lp_lfsr_pkg::TAP_STAGE,
  parameter logic [W-1:0] SEED = lp_lfsr_pkg::SEED
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  output logic [W-1:0] vec_o,
  output logic         valid_o,
  output logic         anchor_o
);
  localparam int unsigned PW = (N_GRP > 1) ? $clog2(N_GRP) : 1;

  logic [W-1:0]  state, nxt;
  logic [PW-1:0] phase;
  logic          wrap;
  logic          valid_q;

  lp_lfsr_phase #(.N_GRP(N_GRP)) u_phase (
    .clk_i, .rst_ni, .en_i, .load_i,
    .phase_o(phase), .wrap_o(wrap)
  );

  lp_lfsr_core #(.W(W), .TAP(TAP), .SEED(SEED)) u_core (
    .clk_i, .rst_ni,
    .adv_i(wrap), .load_i,
    .state_o(state), .next_o(nxt)
  );

  lp_lfsr_blend #(.W(W), .N_GRP(N_GRP)) u_blend (
    .present_i(state), .next_i(nxt), .phase_i(phase), .vec_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= en_i;
  end

  assign valid_o  = valid_q;
  assign anchor_o = (phase == '0);
endmodule

// File: rtl/lp_lfsr_chk.sv
module lp_lfsr_chk #(
  parameter int unsigned W     = 36,
  parameter int unsigned N_GRP = 4,
  parameter int unsigned TAP   = 11,
  parameter logic [W-1:0] SEED = '0
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic         load_i,
  input logic [W-1:0] vec_o,
  input logic         valid_o,
  input logic         anchor_o
);
  localparam int unsigned CW = (N_GRP > 1) ? $clog2(N_GRP) : 1;

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  t1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      t1_q  <= SEED;
    end else if (load_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (cnt_q == '0) t1_q <= vec_o;
      cnt_q <= (cnt_q == CW'(N_GRP - 1)) ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: true state after a wrap is one register step from the captured one
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && cnt_q == CW'(N_GRP - 1))
      |=> (vec_o == {t1_q[W-2:0], t1_q[W-1] ^ t1_q[TAP-1]}));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> ($stable(vec_o) && $stable(anchor_o)));

  a_r6_anchor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    anchor_o == (cnt_q == '0));

  a_r7_valid_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> valid_o);

  a_r7_valid_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);

  a_r8_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (vec_o == SEED && anchor_o));
endmodule

bind lp_lfsr_gen lp_lfsr_chk #(.W(W), .N_GRP(N_GRP), .TAP(TAP), .SEED(SEED)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .load_i(load_i),
  .vec_o(vec_o), .valid_o(valid_o), .anchor_o(anchor_o)
);

// File: tb/lp_lfsr_gen_tb_top.sv
module lp_lfsr_gen_tb_top;
  localparam logic [35:0] SEED_V = 36'b010010100101101011010010100101101011;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        load_i = 1'b0;
  logic [35:0] vec_o;
  logic        valid_o;
  logic        anchor_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [35:0] m_state;
  int          m_phase;
  logic        m_valid;

  always #2 clk_i = ~clk_i;

  lp_lfsr_gen dut_i (.*);

  function automatic logic [35:0] step(logic [35:0] s);
    return {s[34:0], s[35] ^ s[10]};
  endfunction

  function automatic logic [35:0] blend(logic [35:0] s, int p);
    logic [35:0] n = step(s);
    logic [35:0] r = s;
    for (int g = 0; g < 4; g++)
      if (g < p) r[g*9 +: 9] = n[g*9 +: 9];
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [35:0] act, logic [35:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // check outputs against model, drive inputs, advance model to the next edge
  task automatic cycle(bit en, bit ld);
    chk(vec_o == blend(m_state, m_phase), "R4", vec_o, blend(m_state, m_phase));
    chk(anchor_o == (m_phase == 0), "R6", 36'(anchor_o), 36'(m_phase == 0));
    chk(valid_o == m_valid, "R7", 36'(valid_o), 36'(m_valid));
    en_i   = en;
    load_i = ld;
    m_valid = en;
    if (ld) begin
      m_state = SEED_V;
      m_phase = 0;
    end else if (en) begin
      if (m_phase == 3) m_state = step(m_state);
      m_phase = (m_phase + 1) % 4;
    end
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [35:0] prev, t1, mask, cur, held;
    bit seen [logic [35:0]];
    void'($urandom(32'h5eed_1234));
    m_state = SEED_V; m_phase = 0; m_valid = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(vec_o == SEED_V && anchor_o && !valid_o, "R1 in reset", vec_o, SEED_V);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(vec_o == SEED_V && anchor_o && !valid_o, "R1 after release", vec_o, SEED_V);

    // R2: four enabled cycles land on one register step
    repeat (4) cycle(1'b1, 1'b0);
    chk(vec_o == step(SEED_V), "R2 first step", vec_o, step(SEED_V));

    // R3: hold with enable low in mid phase
    cycle(1'b1, 1'b0);
    held = vec_o;
    repeat (5) cycle(1'b0, 1'b0);
    chk(vec_o == held && !anchor_o, "R3 hold", vec_o, held);

    // R8: load wins over enable in mid phase
    cycle(1'b1, 1'b0);
    cycle(1'b1, 1'b1);
    chk(vec_o == SEED_V && anchor_o, "R8 load mid phase", vec_o, SEED_V);

    // random mix
    for (int i = 0; i < 3000; i++)
      cycle(($urandom % 5) != 0, ($urandom % 97) == 0);

    // long run from a clean start: R5 single toggle, R9 no repeat
    cycle(1'b0, 1'b1);
    chk(vec_o == SEED_V, "R8 reload", vec_o, SEED_V);
    prev = vec_o; t1 = vec_o; mask = '0;
    seen[vec_o] = 1'b1;
    for (int i = 0; i < 40000; i++) begin
      cycle(1'b1, 1'b0);
      cur = vec_o;
      chk(((cur ^ prev) & mask) == '0, "R5 bit toggled twice", cur ^ prev, '0);
      mask |= cur ^ prev;
      if (anchor_o) begin
        chk($countones(mask) == $countones(cur ^ t1), "R5 toggle total",
            36'($countones(mask)), 36'($countones(cur ^ t1)));
        chk(!seen.exists(cur), "R9 repeat", cur, t1);
        seen[cur] = 1'b1;
        t1 = cur;
        mask = '0;
      end
      prev = cur;
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule